// File: doc/BRIEF.md
# Event-Driven Leaky Integrate-and-Fire Neuron

This block models a single leaky integrate-and-fire neuron whose state changes only when an input event is accepted. Each event gives two things: the time gap since the previous event and a ternary weight code for the incoming spike. On acceptance, the stored membrane potential leaks by one halving per time step. The leak is done as an arithmetic right shift by the gap. The selected weight is then added with saturation.

If the result reaches the unit threshold, the neuron emits a one-cycle output spike and the threshold is subtracted from the potential. The datapath is a shifter, a weight multiplexer, one adder and one comparator around a single potential register. It contains no multiplier.

An upstream sorter delivers events in time order through a valid/ready handshake. A synchronous clear returns the neuron to rest between inferences. The potential is visible on an output for observation by downstream logic.

Top module: `lif_event_core`

## Requirements
- R1: While rst_ni is low and on release, pot_o is 0 and spike_o is 0.
- R2: An accepted event with gap dt (0 <= dt < 16) first shifts the signed potential arithmetically right by dt bits. A gap of 0 applies no leak.
- R3: When dt is 16 or more, the leaked potential is 0 if the potential was non-negative and -1 LSB if it was negative.
- R4: Weight code 2'b01 adds +1.0 (16'sh0100) and code 2'b11 adds -1.0. Codes 2'b00 and 2'b10 add 0. An event with code 2'b00 or 2'b10 and dt = 0 leaves pot_o unchanged and gives no spike.
- R5: The potential is signed 16-bit with 8 fractional bits. If the leaked-plus-weighted value is 16'sh0100 or more, a spike is produced and 16'sh0100 is subtracted.
- R6: spike_o is high for exactly the one cycle after the edge that accepts a firing event. spike_o is low in every other cycle.
- R7: The addition saturates at -32768 and 32767 instead of wrapping. For example, repeated -1.0 events stay at -32768.
- R8: While clear_i is high, evt_ready_o is low and any offered event is dropped. After that edge, pot_o is 0 and spike_o is 0.
- R9: evt_ready_o is high whenever clear_i is low, so one event is taken per clock. Events with dt = 0 accumulate back to back. pot_o shows each update in the cycle after acceptance and holds otherwise.
- R10: After every update the potential is below 16'sh0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of potential and spike |
| evt_valid_i | input | 1 | Event offered |
| evt_ready_o | output | 1 | Event can be taken this cycle |
| evt_dt_i | input | 5 | Time gap since previous event |
| evt_wcode_i | input | 2 | Ternary weight code |
| spike_o | output | 1 | Output spike strobe |
| pot_o | output | 16 | Membrane potential, signed Q7.8 |

## Verification
The bench targets four areas. Large gaps applied to negative potentials must settle at -1 LSB; a logical shift would leave a large positive value, and a shift by dt modulo 16 would leave the wrong value. Long runs of -1.0 weights pin the potential at -32768; a wrapping adder would jump to a large positive value and fire. The reserved weight code is checked to add nothing, and a wrong decode shows up as a step in pot_o. Clear is asserted together with an offered event; a design that lets the event through shows a nonzero potential or a spike after the clear.

// File: rtl/lif_pkg.sv
package lif_pkg;
  typedef enum logic [1:0] {
    W_ZERO = 2'b00,
    W_POS  = 2'b01,
    W_RSV  = 2'b10,
    W_NEG  = 2'b11
  } w_code_e;
endpackage

// File: rtl/lif_leak_shift.sv
module lif_leak_shift #(
  parameter int P_W  = 16,
  parameter int DT_W = 5
) (
  input  logic signed [P_W-1:0]  pot_i,
  input  logic        [DT_W-1:0] dt_i,
  output logic signed [P_W-1:0]  pot_o
);
  localparam int SH_W = $clog2(P_W);
  localparam int ST_N = (DT_W < SH_W) ? DT_W : SH_W;

  logic signed [P_W-1:0] stg [0:ST_N];
  logic                  ovf;

  assign stg[0] = pot_i;

  for (genvar k = 0; k < ST_N; k++) begin : g_stage
    assign stg[k+1] = dt_i[k] ? (stg[k] >>> (1 << k)) : stg[k];
  end

  if (DT_W > SH_W) begin : g_ovf
    assign ovf = |dt_i[DT_W-1:SH_W];
  end else begin : g_no_ovf
    assign ovf = 1'b0;
  end

  // gap beyond width: only sign bits survive
  assign pot_o = ovf ? {P_W{pot_i[P_W-1]}} : stg[ST_N];
endmodule

// File: rtl/lif_weight_mux.sv
module lif_weight_mux
  import lif_pkg::*;
#(
  parameter int P_W    = 16,
  parameter int FRAC_W = 8
) (
  input  logic [1:0]            code_i,
  output logic signed [P_W-1:0] inc_o
);
  localparam logic signed [P_W-1:0] ONE = P_W'(1) <<< FRAC_W;

  always_comb begin
    unique case (w_code_e'(code_i))
      W_POS:   inc_o = ONE;
      W_NEG:   inc_o = -ONE;
      default: inc_o = '0;
    endcase
  end
endmodule

// File: rtl/lif_accum.sv
module lif_accum #(
  parameter int P_W    = 16,
  parameter int FRAC_W = 8
) (
  input  logic signed [P_W-1:0] leak_i,
  input  logic signed [P_W-1:0] inc_i,
  output logic signed [P_W-1:0] pot_o,
  output logic                  fire_o
);
  localparam logic signed [P_W-1:0] THR   = P_W'(1) <<< FRAC_W;
  localparam logic signed [P_W-1:0] S_MAX = {1'b0, {(P_W-1){1'b1}}};
  localparam logic signed [P_W-1:0] S_MIN = {1'b1, {(P_W-1){1'b0}}};

  logic signed [P_W:0]   sum;
  logic signed [P_W-1:0] sat;

  assign sum = {leak_i[P_W-1], leak_i} + {inc_i[P_W-1], inc_i};

  always_comb begin
    if (sum[P_W] != sum[P_W-1]) sat = sum[P_W] ? S_MIN : S_MAX;
    else                        sat = sum[P_W-1:0];
  end

  assign fire_o = (sat >= THR);
  assign pot_o  = fire_o ? (sat - THR) : sat;
endmodule

// File: rtl/lif_event_core.sv
module lif_event_core #(
  parameter int P_W    = 16,
  parameter int FRAC_W = 8,
  parameter int DT_W   = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  evt_valid_i,
  output logic                  evt_ready_o,
  input  logic [DT_W-1:0]       evt_dt_i,
  input  logic [1:0]            evt_wcode_i,
  output logic                  spike_o,
  output logic signed [P_W-1:0] pot_o
);
  logic signed [P_W-1:0] pot_q, leak, inc, pot_nxt;
  logic                  fire, spike_q, take;

  assign evt_ready_o = ~clear_i;
  assign take        = evt_valid_i & evt_ready_o;

  lif_leak_shift #(.P_W(P_W), .DT_W(DT_W)) u_leak (
    .pot_i (pot_q),
    .dt_i  (evt_dt_i),
    .pot_o (leak)
  );

  lif_weight_mux #(.P_W(P_W), .FRAC_W(FRAC_W)) u_wmux (
    .code_i (evt_wcode_i),
    .inc_o  (inc)
  );

  lif_accum #(.P_W(P_W), .FRAC_W(FRAC_W)) u_acc (
    .leak_i (leak),
    .inc_i  (inc),
    .pot_o  (pot_nxt),
    .fire_o (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pot_q   <= '0;
      spike_q <= 1'b0;
    end else if (clear_i) begin
      pot_q   <= '0;
      spike_q <= 1'b0;
    end else if (take) begin
      pot_q   <= pot_nxt;
      spike_q <= fire;
    end else begin
      spike_q <= 1'b0;
    end
  end

  assign spike_o = spike_q;
  assign pot_o   = pot_q;
endmodule

module lif_event_core_chk #(
  parameter int P_W    = 16,
  parameter int FRAC_W = 8,
  parameter int DT_W   = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  clear_i,
  input logic                  evt_valid_i,
  input logic                  evt_ready_o,
  input logic [DT_W-1:0]       evt_dt_i,
  input logic [1:0]            evt_wcode_i,
  input logic                  spike_o,
  input logic signed [P_W-1:0] pot_o
);
  localparam logic signed [P_W-1:0] THR = P_W'(1) <<< FRAC_W;

  // R10
  pot_below_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pot_o < THR);

  // R8
  clear_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (pot_o == '0) && !spike_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_valid_i && !clear_i) |=> $stable(pot_o) && !spike_o);

  // R4
  zero_weight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_ready_o && evt_dt_i == '0 && !evt_wcode_i[0])
      |=> $stable(pot_o) && !spike_o);

  // R6
  spike_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spike_o |-> $past(evt_valid_i && evt_ready_o));
endmodule

bind lif_event_core lif_event_core_chk #(.P_W(P_W), .FRAC_W(FRAC_W), .DT_W(DT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clear_i     (clear_i),
  .evt_valid_i (evt_valid_i),
  .evt_ready_o (evt_ready_o),
  .evt_dt_i    (evt_dt_i),
  .evt_wcode_i (evt_wcode_i),
  .spike_o     (spike_o),
  .pot_o       (pot_o)
);

// File: tb/sim_lif_event_core.sv
module sim_lif_event_core;
  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              clear_i = 1'b0;
  logic              evt_valid_i = 1'b0;
  logic              evt_ready_o;
  logic [4:0]        evt_dt_i = '0;
  logic [1:0]        evt_wcode_i = '0;
  logic              spike_o;
  logic signed [15:0] pot_o;

  int n_run = 0, n_fail = 0;
  int exp_pot = 0;
  bit exp_spk = 1'b0;
  bit done = 1'b0;

  always #5ns clk_i = ~clk_i;

  lif_event_core u0 (.*);

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int leak_of(int p, int dt);
    if (dt >= 16) return (p < 0) ? -1 : 0;
    return p >>> dt;
  endfunction

  // called at a negedge; returns at the next negedge after checking
  task automatic step(bit v, int dt, int wc, bit clr, string tag);
    int s, w;
    bit f;
    evt_valid_i = v; evt_dt_i = 5'(dt); evt_wcode_i = 2'(wc); clear_i = clr;
    #1;
    chk({tag, " R8 R9 ready"}, int'(evt_ready_o), int'(!clr));
    if (clr) begin
      exp_pot = 0; exp_spk = 0;
    end else if (v) begin
      w = (wc == 1) ? 256 : (wc == 3) ? -256 : 0;
      s = leak_of(exp_pot, dt) + w;
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      f = (s >= 256);
      exp_pot = f ? s - 256 : s;
      exp_spk = f;
    end else begin
      exp_spk = 0;
    end
    @(negedge clk_i);
    chk({tag, " pot"}, int'(pot_o), exp_pot);
    chk({tag, " spike"}, int'(spike_o), int'(exp_spk));
  endtask

  initial begin
    #2ms;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_1234);
    #12ns;
    chk("R1 pot", int'(pot_o), 0);
    chk("R1 spike", int'(spike_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 pot", int'(pot_o), 0);

    step(1, 0, 1, 0, "R5");   // 0+1.0 fires, back to 0
    step(1, 0, 3, 0, "R4");   // -256
    step(1, 1, 3, 0, "R2");   // -128-256
    step(1, 1, 1, 0, "R2");   // -192+256 = 64
    step(1, 0, 1, 0, "R9");   // 320 fires -> 64
    step(1, 0, 1, 0, "R9");   // again
    step(0, 0, 0, 0, "R6");   // idle, spike drops
    step(1, 3, 0, 0, "R2");   // 8
    step(1, 16, 0, 0, "R3");  // 0
    step(1, 0, 3, 0, "R3");   // -256
    step(1, 20, 0, 0, "R3");  // -1
    step(1, 31, 2, 0, "R3");  // -1 stays
    for (int i = 0; i < 130; i++) step(1, 0, 3, 0, "R7");
    step(1, 1, 0, 0, "R7");   // -16384
    step(1, 0, 2, 0, "R4");   // reserved code, no change
    step(1, 0, 0, 0, "R4");
    step(1, 0, 1, 1, "R8");   // clear wins over event
    step(1, 0, 1, 0, "R5");

    for (int i = 0; i < 6000; i++) begin
      bit v, c;
      int dt, wc;
      string t;
      v  = ($urandom % 4) != 0;
      c  = ($urandom % 40) == 0;
      dt = (($urandom % 4) == 0) ? int'($urandom % 32) : int'($urandom % 4);
      wc = int'($urandom % 8);
      wc = (wc < 3) ? 1 : (wc < 5) ? 3 : (wc == 5) ? 2 : 0;
      if (c) t = "R8";
      else if (!v) t = "R6";
      else if (dt >= 16) t = "R3";
      else if (wc == 2) t = "R4";
      else if (wc == 1) t = "R5";
      else t = "R2";
      step(v, dt, wc, c, t);
      if (pot_o >= 16'sh0100) chk("R10", int'(pot_o), 255);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule